// File: doc/BRIEF.md
# TDM Row Sequencer with Per-Row Flux-Locked Loop

This block drives row addressing for a time-division-multiplexed sensor readout. One row is selected at a time, the rows are visited in ascending order, and one pass over all rows makes a frame. Each row period begins with a settling interval, during which incoming ADC samples are discarded. A short integration window follows, during which the samples are summed. When the window closes, the block reports the sum as that row's error. The error then advances a digital flux-locked-loop integrator held for that row alone.

Each row has its own feedback code in a register file indexed by row. The code of the row that is currently selected is always present on the output, ready for the feedback DAC. The row count, the row length, the settle length and the window length are all counted in clock cycles. A new configuration takes effect only at a frame boundary, so a frame never mixes two timings. The window can be placed right against the end of the row by setting the settle length to the row length minus the window length. This keeps the window as far as possible from the switching transient.

Top module: `tdm_row_sequencer`

## Requirements
- R1: `row_sel` is one-hot at every cycle. Bit i is set while row i is active, and rows advance 0, 1, ..., rows-1 before wrapping to 0.
- R2: Each row lasts exactly the active row length in clock cycles. A frame holds the active number of rows, which may be anywhere from 1 to 48, including 16, 24, 32 and 48.
- R3: Configuration inputs are sampled only in the last cycle of a frame, and they take effect from the first cycle of the next row 0. Changes made earlier in a frame have no effect on that frame.
- R4: A configuration is rejected, and the previous one is kept, in any of these cases: settle plus window exceeds the row length; the window is 0 or above 16; the row count is 0 or above 48; the row length is 0.
- R5: Within a row, the cycles numbered settle through settle+window-1 (counting from 0 at the row start) are the only ones whose `adc_sample` values are summed. All other samples are ignored.
- R6: `err_valid` is high for exactly one cycle, the cycle after the last window sample. In that cycle `err_row` holds the row index and `err_value` holds the signed sum of the window samples.
- R7: Each reported error updates that row's code once. The new code is the old code plus the error arithmetically shifted right by GAIN_SH (2 by default), and the result is saturated to the range 0 to 16383. The new code is visible from the cycle after `err_valid`.
- R8: `fb_code` always shows the stored code of the row selected in the same cycle.
- R9: `frame_start` is high on the first cycle of row 0 and in no other cycle.
- R10: After reset, the sequencer is at row 0, cycle 0, and `err_valid` is low. Every row code reads 8192 (mid-scale), and the active configuration is 16 rows of 40 cycles with a settle of 24 and a window of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rows | input | 6 | Requested rows per frame |
| cfg_row_cyc | input | 8 | Requested row length in cycles |
| cfg_settle | input | 8 | Requested settle length in cycles |
| cfg_win | input | 5 | Requested integration window in cycles |
| adc_sample | input | 12 | Signed ADC sample for the current cycle |
| row_sel | output | 48 | One-hot row enable |
| frame_start | output | 1 | First cycle of row 0 |
| err_valid | output | 1 | Integrated error available |
| err_row | output | 6 | Row the error belongs to |
| err_value | output | 16 | Signed window sum |
| fb_code | output | 14 | Feedback code of the selected row |

## Verification
Two situations are hard to reach from the ports. The first is a configuration that arrives mid-frame. The second is one that is invalid only in its settle-plus-window relation. Both can be observed only through how long later rows last. The bench therefore changes the configuration inputs a few cycles into a frame and holds them there, and it also presents invalid sets on the same cycle as a frame boundary. It then compares `row_sel` against an arithmetic model on every cycle, so that any row timing changed too early, or changed when it should have been kept, shows up as a misaligned row edge. Saturation at both ends of the code range is reached by driving full-scale samples of each sign for several frames.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

  // Legality of a requested row timing, evaluated on integer copies.
  function automatic logic cfg_ok(int rows, int cyc, int settle, int win,
                                  int max_rows, int max_win);
    return (rows >= 1) && (rows <= max_rows) && (cyc >= 1) &&
           (win >= 1) && (win <= max_win) && (settle + win <= cyc);
  endfunction

  // One loop-integrator step: shifted error added, clamped to the code span.
  function automatic int fll_next(int code, int err, int shift, int code_max);
    int step;
    int sum;
    step = err >>> shift;
    sum  = code + step;
    if (sum < 0)        return 0;
    if (sum > code_max) return code_max;
    return sum;
  endfunction

endpackage

// File: rtl/tdm_row_timer.sv
module tdm_row_timer #(
  parameter int MAX_ROWS   = 48,
  parameter int CYC_W      = 8,
  parameter int MAX_WIN    = 16,
  parameter int DEF_ROWS   = 16,
  parameter int DEF_CYC    = 40,
  parameter int DEF_SETTLE = 24,
  parameter int DEF_WIN    = 16,
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1),
  localparam int WIN_W  = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RCNT_W-1:0] cfg_rows,
  input  logic [CYC_W-1:0]  cfg_row_cyc,
  input  logic [CYC_W-1:0]  cfg_settle,
  input  logic [WIN_W-1:0]  cfg_win,
  output logic [ROW_W-1:0]  row_idx,
  output logic              frame_start,
  output logic              frame_end,
  output logic              win_active,
  output logic              win_first,
  output logic              win_last,
  output logic [RCNT_W-1:0] act_rows,
  output logic [CYC_W-1:0]  act_cyc,
  output logic [CYC_W-1:0]  act_settle,
  output logic [WIN_W-1:0]  act_win
);
  import tdm_seq_pkg::*;

  localparam int CW1 = CYC_W + 1;

  logic [CYC_W-1:0] cyc_idx;
  logic             row_end;
  logic [CW1-1:0]   win_stop;
  logic             new_ok;

  assign row_end     = (cyc_idx == act_cyc - CYC_W'(1));
  assign frame_end   = row_end && (RCNT_W'(row_idx) == act_rows - RCNT_W'(1));
  assign frame_start = (row_idx == '0) && (cyc_idx == '0);

  assign win_stop   = CW1'(act_settle) + CW1'(act_win);
  assign win_active = (CW1'(cyc_idx) >= CW1'(act_settle)) &&
                      (CW1'(cyc_idx) < win_stop);
  assign win_first  = win_active && (cyc_idx == act_settle);
  assign win_last   = (CW1'(cyc_idx) + CW1'(1)) == win_stop;

  assign new_ok = cfg_ok(int'(cfg_rows), int'(cfg_row_cyc), int'(cfg_settle),
                         int'(cfg_win), MAX_ROWS, MAX_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_idx    <= '0;
      row_idx    <= '0;
      act_rows   <= RCNT_W'(DEF_ROWS);
      act_cyc    <= CYC_W'(DEF_CYC);
      act_settle <= CYC_W'(DEF_SETTLE);
      act_win    <= WIN_W'(DEF_WIN);
    end else if (row_end) begin
      cyc_idx <= '0;
      if (frame_end) begin
        row_idx <= '0;
        if (new_ok) begin
          act_rows   <= cfg_rows;
          act_cyc    <= cfg_row_cyc;
          act_settle <= cfg_settle;
          act_win    <= cfg_win;
        end
      end else begin
        row_idx <= row_idx + ROW_W'(1);
      end
    end else begin
      cyc_idx <= cyc_idx + CYC_W'(1);
    end
  end

endmodule

// File: rtl/tdm_window_integ.sv
module tdm_window_integ #(
  parameter int SAMP_W = 12,
  parameter int ACC_W  = 16,
  parameter int ROW_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_active,
  input  logic                    win_first,
  input  logic                    win_last,
  input  logic [ROW_W-1:0]        row_idx,
  input  logic signed [SAMP_W-1:0] sample,
  output logic                    err_valid,
  output logic [ROW_W-1:0]        err_row,
  output logic signed [ACC_W-1:0] err_value
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sample_x;
  logic signed [ACC_W-1:0] sum_now;

  assign sample_x = ACC_W'(sample);
  assign sum_now  = win_first ? sample_x : acc + sample_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      err_valid <= 1'b0;
      err_row   <= '0;
      err_value <= '0;
    end else begin
      if (win_active) acc <= sum_now;
      err_valid <= win_last;
      if (win_last) begin
        err_row   <= row_idx;
        err_value <= sum_now;
      end
    end
  end

endmodule

// File: rtl/tdm_fll_bank.sv
module tdm_fll_bank #(
  parameter int MAX_ROWS = 48,
  parameter int ACC_W    = 16,
  parameter int CODE_W   = 14,
  parameter int GAIN_SH  = 2,
  localparam int ROW_W    = $clog2(MAX_ROWS),
  localparam int CODE_MAX = (1 << CODE_W) - 1,
  localparam int CODE_MID = 1 << (CODE_W - 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic signed [ACC_W-1:0] wr_err,
  input  logic [ROW_W-1:0]        rd_row,
  output logic [CODE_W-1:0]       rd_code,
  output logic [CODE_W-1:0]       wr_code
);
  import tdm_seq_pkg::*;

  logic [CODE_W-1:0] code_q [MAX_ROWS];

  assign wr_code = CODE_W'(fll_next(int'(code_q[wr_row]), int'(wr_err),
                                    GAIN_SH, CODE_MAX));
  assign rd_code = code_q[rd_row];

  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[r] <= CODE_W'(CODE_MID);
      else if (wr_en && (wr_row == ROW_W'(r)))
        code_q[r] <= wr_code;
    end
  end

endmodule

// File: rtl/tdm_row_sequencer.sv
module tdm_row_sequencer #(
  parameter int MAX_ROWS   = 48,
  parameter int CYC_W      = 8,
  parameter int MAX_WIN    = 16,
  parameter int SAMP_W     = 12,
  parameter int CODE_W     = 14,
  parameter int GAIN_SH    = 2,
  parameter int DEF_ROWS   = 16,
  parameter int DEF_CYC    = 40,
  parameter int DEF_SETTLE = 24,
  parameter int DEF_WIN    = 16,
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1),
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int ACC_W  = SAMP_W + $clog2(MAX_WIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RCNT_W-1:0]        cfg_rows,
  input  logic [CYC_W-1:0]         cfg_row_cyc,
  input  logic [CYC_W-1:0]         cfg_settle,
  input  logic [WIN_W-1:0]         cfg_win,
  input  logic signed [SAMP_W-1:0] adc_sample,
  output logic [MAX_ROWS-1:0]      row_sel,
  output logic                     frame_start,
  output logic                     err_valid,
  output logic [ROW_W-1:0]         err_row,
  output logic signed [ACC_W-1:0]  err_value,
  output logic [CODE_W-1:0]        fb_code
);

  logic [ROW_W-1:0]  row_idx;
  logic              frame_end;
  logic              win_active;
  logic              win_first;
  logic              win_last;
  logic [RCNT_W-1:0] act_rows;
  logic [CYC_W-1:0]  act_cyc;
  logic [CYC_W-1:0]  act_settle;
  logic [WIN_W-1:0]  act_win;
  logic [CODE_W-1:0] upd_code;

  tdm_row_timer #(
    .MAX_ROWS(MAX_ROWS), .CYC_W(CYC_W), .MAX_WIN(MAX_WIN),
    .DEF_ROWS(DEF_ROWS), .DEF_CYC(DEF_CYC),
    .DEF_SETTLE(DEF_SETTLE), .DEF_WIN(DEF_WIN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_rows(cfg_rows), .cfg_row_cyc(cfg_row_cyc),
    .cfg_settle(cfg_settle), .cfg_win(cfg_win),
    .row_idx(row_idx), .frame_start(frame_start), .frame_end(frame_end),
    .win_active(win_active), .win_first(win_first), .win_last(win_last),
    .act_rows(act_rows), .act_cyc(act_cyc),
    .act_settle(act_settle), .act_win(act_win)
  );

  tdm_window_integ #(
    .SAMP_W(SAMP_W), .ACC_W(ACC_W), .ROW_W(ROW_W)
  ) u_integ (
    .clk(clk), .rst_n(rst_n),
    .win_active(win_active), .win_first(win_first), .win_last(win_last),
    .row_idx(row_idx), .sample(adc_sample),
    .err_valid(err_valid), .err_row(err_row), .err_value(err_value)
  );

  tdm_fll_bank #(
    .MAX_ROWS(MAX_ROWS), .ACC_W(ACC_W), .CODE_W(CODE_W), .GAIN_SH(GAIN_SH)
  ) u_fll (
    .clk(clk), .rst_n(rst_n),
    .wr_en(err_valid), .wr_row(err_row), .wr_err(err_value),
    .rd_row(row_idx), .rd_code(fb_code), .wr_code(upd_code)
  );

  for (genvar i = 0; i < MAX_ROWS; i++) begin : g_sel
    assign row_sel[i] = (row_idx == ROW_W'(i));
  end

endmodule

// File: rtl/tdm_row_sequencer_chk.sv
module tdm_row_sequencer_chk #(
  parameter int MAX_ROWS = 48,
  parameter int CYC_W    = 8,
  parameter int MAX_WIN  = 16,
  parameter int CODE_W   = 14,
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1),
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int CW1    = CYC_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [MAX_ROWS-1:0] row_sel,
  input logic                frame_start,
  input logic                frame_end,
  input logic                err_valid,
  input logic [ROW_W-1:0]    err_row,
  input logic [ROW_W-1:0]    row_idx,
  input logic                win_last,
  input logic [RCNT_W-1:0]   act_rows,
  input logic [CYC_W-1:0]    act_cyc,
  input logic [CYC_W-1:0]    act_settle,
  input logic [WIN_W-1:0]    act_win,
  input logic [CODE_W-1:0]   fb_code,
  input logic [CODE_W-1:0]   upd_code
);

  // R1
  rowsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  // R9
  frame_start_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> row_sel[0]);

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_start);

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(act_rows) && $stable(act_cyc) &&
                    $stable(act_settle) && $stable(act_win)));

  // R4
  cfg_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW1'(act_settle) + CW1'(act_win)) <= CW1'(act_cyc));

  // R6
  err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> (err_valid && err_row == $past(row_idx)));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> !err_valid);

  // R7
  code_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && row_sel[err_row]) |=> (row_idx != $past(err_row) ||
                                        fb_code == $past(upd_code)));

endmodule

bind tdm_row_sequencer tdm_row_sequencer_chk #(
  .MAX_ROWS(MAX_ROWS), .CYC_W(CYC_W), .MAX_WIN(MAX_WIN), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .frame_start(frame_start),
  .frame_end(frame_end), .err_valid(err_valid), .err_row(err_row),
  .row_idx(row_idx), .win_last(win_last), .act_rows(act_rows),
  .act_cyc(act_cyc), .act_settle(act_settle), .act_win(act_win),
  .fb_code(fb_code), .upd_code(upd_code)
);

// File: tb/tb_tdm_row_sequencer.sv
module tb_tdm_row_sequencer;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [5:0]         cfg_rows = 6'd16;
  logic [7:0]         cfg_row_cyc = 8'd40;
  logic [7:0]         cfg_settle = 8'd24;
  logic [4:0]         cfg_win = 5'd16;
  logic signed [11:0] adc_sample = '0;
  logic [47:0]        row_sel;
  logic               frame_start;
  logic               err_valid;
  logic [5:0]         err_row;
  logic signed [15:0] err_value;
  logic [13:0]        fb_code;

  always #5 clk = ~clk;

  tdm_row_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_row_cyc(cfg_row_cyc),
    .cfg_settle(cfg_settle), .cfg_win(cfg_win), .adc_sample(adc_sample),
    .row_sel(row_sel), .frame_start(frame_start), .err_valid(err_valid),
    .err_row(err_row), .err_value(err_value), .fb_code(fb_code)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string row_tag = "R1";
  int mode = 0;
  int tick = 0;

  // Reference state, derived from the requirements.
  int m_row, m_cyc, m_rows, m_cc, m_st, m_wn;
  int m_acc, m_eval, m_er;
  bit m_ev;
  int m_fb [48];

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int floor_div4(int v);
    int r;
    r = ((v % 4) + 4) % 4;
    return (v - r) / 4;
  endfunction

  function automatic int clamp_code(int v);
    if (v < 0) return 0;
    if (v > 16383) return 16383;
    return v;
  endfunction

  task automatic model_reset();
    m_row = 0; m_cyc = 0; m_rows = 16; m_cc = 40; m_st = 24; m_wn = 16;
    m_acc = 0; m_eval = 0; m_er = 0; m_ev = 1'b0;
    for (int i = 0; i < 48; i++) m_fb[i] = 8192;
  endtask

  task automatic model_step();
    bit in_win, first, last, good;
    int smp, nsum;
    smp    = int'(adc_sample);
    in_win = (m_cyc >= m_st) && (m_cyc < m_st + m_wn);
    first  = (m_cyc == m_st);
    last   = (m_cyc == m_st + m_wn - 1);
    nsum   = first ? smp : m_acc + smp;
    if (m_ev) m_fb[m_er] = clamp_code(m_fb[m_er] + floor_div4(m_eval));
    m_ev = last;
    if (last) begin m_er = m_row; m_eval = nsum; end
    if (in_win) m_acc = nsum;
    if (m_cyc == m_cc - 1) begin
      m_cyc = 0;
      if (m_row == m_rows - 1) begin
        m_row = 0;
        good = (cfg_rows >= 1) && (cfg_rows <= 48) && (cfg_row_cyc >= 1) &&
               (cfg_win >= 1) && (cfg_win <= 16) &&
               (int'(cfg_settle) + int'(cfg_win) <= int'(cfg_row_cyc));
        if (good) begin
          m_rows = cfg_rows; m_cc = cfg_row_cyc; m_st = cfg_settle; m_wn = cfg_win;
        end
      end else begin
        m_row++;
      end
    end else begin
      m_cyc++;
    end
  endtask

  task automatic compare_outputs();
    logic [47:0] exp_sel;
    exp_sel = 48'd1 << m_row;
    chk(row_sel == exp_sel, row_tag, longint'(row_sel), longint'(exp_sel));
    chk(frame_start == (m_row == 0 && m_cyc == 0), "R9",
        longint'(frame_start), longint'(m_row == 0 && m_cyc == 0));
    chk(err_valid == m_ev, "R6", longint'(err_valid), longint'(m_ev));
    if (m_ev && err_valid) begin
      chk(int'(err_row) == m_er, "R6", longint'(err_row), longint'(m_er));
      chk(int'(err_value) == m_eval, "R5", longint'(err_value), longint'(m_eval));
    end
    chk(int'(fb_code) == m_fb[m_row], (mode >= 2) ? "R7" : "R8",
        longint'(fb_code), longint'(m_fb[m_row]));
  endtask

  function automatic int stim(int t);
    case (mode)
      0: return 0;
      1: return ((t * 7) % 41) - 20;
      2: return 2047;
      3: return -2048;
      default: return ((t * 13) % 97) - 48;
    endcase
  endfunction

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      model_step();
      compare_outputs();
      tick++;
      adc_sample = 12'(stim(tick));
    end
  endtask

  task automatic set_cfg(input int r, input int c, input int s, input int w);
    cfg_rows = 6'(r); cfg_row_cyc = 8'(c); cfg_settle = 8'(s); cfg_win = 5'(w);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state seen at the ports
    chk(row_sel == 48'd1, "R10", longint'(row_sel), 1);
    chk(err_valid == 1'b0, "R10", longint'(err_valid), 0);
    chk(fb_code == 14'd8192, "R10", longint'(fb_code), 8192);
    rst_n = 1'b1;

    // R10: default timing during the first frame, zero input keeps mid-scale
    row_tag = "R10"; mode = 0;
    set_cfg(4, 8, 3, 4);
    run(700);

    // R5 R6 R7: small frame, varied samples
    row_tag = "R2"; mode = 1;
    run(600);
    // R7: saturate high then low
    mode = 2; run(300);
    mode = 3; run(300);
    mode = 4; run(200);

    // R3: change requested timing a few cycles into a frame
    row_tag = "R3";
    run(5);
    set_cfg(3, 12, 2, 5);
    run(400);

    // R4: invalid sets must leave timing unchanged
    row_tag = "R4";
    set_cfg(3, 8, 6, 4);  run(200);
    set_cfg(3, 12, 2, 0); run(150);
    set_cfg(3, 20, 2, 17); run(150);
    set_cfg(0, 12, 2, 4); run(150);
    set_cfg(49, 12, 2, 4); run(150);
    set_cfg(3, 0, 0, 1); run(150);

    // R2: supported row counts, window at row end
    row_tag = "R2";
    set_cfg(16, 40, 24, 16); run(1500);
    set_cfg(24, 10, 2, 8);   run(700);
    set_cfg(32, 9, 0, 9);    run(900);
    set_cfg(1, 5, 1, 4);     run(100);
    row_tag = "R1";
    set_cfg(48, 90, 74, 16); run(9500);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule